// File: doc/BRIEF.md
# Reed-Solomon (255,239) Parity Encoder

This block is a byte-serial systematic Reed-Solomon encoder of the kind used as the forward error correction stage of an optical transport line. A host marks the first byte of each block with a one-cycle START strobe and then streams 239 message bytes, one per clock. The encoder copies every message byte unchanged to its output two clocks later. It then appends 16 check bytes, which completes a 255-byte codeword that can correct up to 8 byte errors.

The check bytes come from a sixteen-stage linear-feedback register of GF(256) bytes. Each stage has its own constant multiplier, derived at elaboration from the generator polynomial. While the check bytes are shifted out, the feedback path is cut, so the register empties itself and the next block can follow without any reset. The codeword is framed by the START strobe alone, and the stream runs at one byte per clock without stalls. For that reason the data interface has no valid/ready handshake, and there is no back-pressure.

Top module: `rs_fec_encoder`

## Requirements
- R1: Arithmetic is in GF(256) with reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D), where alpha is the element 0x02. The generator polynomial is the product of (z + alpha^i) for i = 0..15. Every emitted 255-byte codeword, read with its first byte as the coefficient of z^254, evaluates to zero at alpha^0 through alpha^15.
- R2: A high `start_i` marks the cycle that carries the first message byte. The codeword on `data_o` is exactly 239 message bytes, followed directly by 16 parity bytes.
- R3: A byte presented at a rising edge appears on `data_o` after the second rising edge that follows it, which is a latency of two clocks.
- R4: The 239 message bytes appear on `data_o` unchanged and in their input order.
- R5: The 16 parity bytes are the remainder of m(z)·z^16 divided by the generator polynomial. They are emitted from the z^15 coefficient (codeword position 240) down to the z^0 coefficient (position 255). An all-zero message gives all-zero parity. A message whose only nonzero byte is a final 0x01 gives the generator's coefficients from z^15 down to z^0.
- R6: After the last parity byte, every register stage is zero. A START placed exactly 255 cycles after the previous one gives a correct codeword with no reset between the two.
- R7: `data_i` is ignored during the parity phase and while idle. Bytes driven there do not change any parity byte.
- R8: `data_o` is 0x00 in every cycle that carries no codeword byte.
- R9: `rst` is active-high and synchronous. It clears the pipeline and all parity stages, so `data_o` is 0x00 while it is held. A block started after a reset that interrupted an earlier block is encoded correctly.
- R10: A START less than 255 cycles after the previous one is a protocol violation, and the bench flags it. The design abandons the open codeword and begins a fresh one from cleared stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | High with the first message byte of a block |
| data_i | input | 8 | Message byte stream |
| data_o | output | 8 | Message pass-through, then parity, else 0x00 |

## Verification
Two events can fall in the same cycle: the shift that moves the last parity byte out and clears the stages, and the capture of a new block's first byte into the input register. The bench provokes this by starting blocks exactly 255 cycles apart, with no idle gap. It judges the result by the seamless output stream and by checking the second codeword's parity against an independent long division and against zero syndromes. A second pairing puts a premature START on top of an open parity or message phase. There, the bench expects the fresh codeword to be exact and the violation to be reported once.

// File: rtl/rs_fec_pkg.sv
package rs_fec_pkg;

  localparam int SYM_W = 8;
  // low byte of x^8+x^4+x^3+x^2+1
  localparam logic [SYM_W-1:0] PRIM_LOW = 8'h1D;
  // generator arrays inside gen_coef are sized for up to this many parity bytes
  localparam int MAX_PAR = 63;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MSG  = 2'd1,
    PH_PAR  = 2'd2
  } phase_e;

  // shift-and-add GF(256) product
  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? PRIM_LOW : '0);
    end
    return acc;
  endfunction

  function automatic sym_t alpha_pow(input int n);
    sym_t v;
    v = 8'h01;
    for (int i = 0; i < n; i++) v = gf_mul(v, 8'h02);
    return v;
  endfunction

  // coefficient k of prod_{i=0}^{npar-1} (z + alpha^(first_root+i))
  function automatic sym_t gen_coef(input int npar, input int k, input int first_root);
    sym_t g [0:MAX_PAR];
    sym_t r;
    for (int j = 0; j <= MAX_PAR; j++) g[j] = '0;
    g[0] = 8'h01;
    for (int i = 0; i < npar; i++) begin
      r = alpha_pow(first_root + i);
      for (int j = npar; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], r);
      g[0] = gf_mul(g[0], r);
    end
    return g[k];
  endfunction

endpackage

// File: rtl/rs_fec_seq.sv
module rs_fec_seq #(
  parameter int NMSG = 239,
  parameter int NPAR = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_q,
  output rs_fec_pkg::phase_e   phase,
  output logic                 last_shift
);
  import rs_fec_pkg::*;

  localparam int NTOT = NMSG + NPAR;
  localparam int CW   = $clog2(NTOT);
  localparam logic [CW-1:0] LAST    = CW'(NTOT - 1);
  localparam logic [CW-1:0] MSG_END = CW'(NMSG);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pos;
  logic          busy_q;
  logic          act;

  // position of the byte now in the input register
  always_comb begin
    pos        = start_q ? '0 : cnt_q;
    act        = start_q | busy_q;
    last_shift = act && (pos == LAST);
    if (!act)               phase = PH_IDLE;
    else if (pos < MSG_END) phase = PH_MSG;
    else                    phase = PH_PAR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (act) begin
      if (pos == LAST) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q  <= pos + 1'b1;
        busy_q <= 1'b1;
      end
    end
  end

  // R2: position never runs past the codeword end
  assert_pos_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= LAST));

  // R2: a codeword closes only after its final byte position
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/rs_fec_lfsr.sv
module rs_fec_lfsr #(
  parameter int NPAR = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  rs_fec_pkg::phase_e  phase,
  input  logic                restart,
  input  logic                last_shift,
  input  rs_fec_pkg::sym_t    din,
  output rs_fec_pkg::sym_t    par_o
);
  import rs_fec_pkg::*;

  sym_t st_q [NPAR];
  sym_t st_d [NPAR];
  sym_t fb;
  logic any_nz;

  // a restart sees the stages as empty
  assign fb = din ^ (restart ? '0 : st_q[NPAR-1]);

  generate
    for (genvar i = 0; i < NPAR; i++) begin : g_stage
      localparam sym_t COEF = gen_coef(NPAR, i, 0);
      sym_t prev;
      sym_t prod;
      if (i == 0) begin : g_head
        assign prev = '0;
      end else begin : g_body
        assign prev = restart ? '0 : st_q[i-1];
      end
      assign prod    = gf_mul(fb, COEF);
      // parity phase: plain shift toward the output, zero into stage 0
      assign st_d[i] = (phase == PH_MSG) ? (prev ^ prod) :
                       (phase == PH_PAR) ? prev : st_q[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAR; i++) st_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPAR; i++) st_q[i] <= st_d[i];
    end
  end

  assign par_o = st_q[NPAR-1];

  always_comb begin
    any_nz = 1'b0;
    for (int i = 0; i < NPAR; i++) any_nz = any_nz | (|st_q[i]);
  end

  // R6: the stages are empty once the last parity byte has been shifted
  assert_stages_clear_R6: assert property (@(posedge clk) disable iff (rst)
    last_shift |=> !any_nz);

endmodule

// File: rtl/rs_fec_encoder.sv
module rs_fec_encoder #(
  parameter int NMSG = 239,
  parameter int NPAR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o
);
  import rs_fec_pkg::*;

  sym_t   din_q;
  logic   start_q;
  sym_t   out_q;
  sym_t   out_d;
  sym_t   par_top;
  phase_e phase;
  logic   last_shift;

  // first pipeline register: input capture
  always_ff @(posedge clk) begin
    if (rst) begin
      din_q   <= '0;
      start_q <= 1'b0;
    end else begin
      din_q   <= data_i;
      start_q <= start_i;
    end
  end

  rs_fec_seq #(.NMSG(NMSG), .NPAR(NPAR)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_q    (start_q),
    .phase      (phase),
    .last_shift (last_shift)
  );

  rs_fec_lfsr #(.NPAR(NPAR)) u_lfsr (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .restart    (start_q),
    .last_shift (last_shift),
    .din        (din_q),
    .par_o      (par_top)
  );

  always_comb begin
    case (phase)
      PH_MSG:  out_d = din_q;
      PH_PAR:  out_d = par_top;
      default: out_d = '0;
    endcase
  end

  // second pipeline register: output
  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= out_d;
  end

  assign data_o = out_q;

  // R8: a cycle without a codeword byte yields 0x00
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |=> (data_o == 8'h00));

  // R4: message bytes leave unchanged one edge after capture
  assert_msg_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MSG) |=> (data_o == $past(din_q)));

endmodule

// File: tb/rs_fec_encoder_bench.sv
module rs_fec_encoder_bench;

  localparam int NMSG = 239;
  localparam int NPAR = 16;
  localparam int NTOT = 255;

  // stimulus vectors: {pattern, seed, idle gap after codeword}
  // patterns: 0 zeros (expect zero parity), 1 final 0x01 (expect generator),
  // 2 counting from seed, 3 pseudo-random from seed, 4 all 0xFF
  localparam logic [23:0] VEC [0:6] = '{
    {8'd0, 8'h00, 8'd3},
    {8'd1, 8'h00, 8'd2},
    {8'd2, 8'h05, 8'd0},
    {8'd3, 8'hA7, 8'd0},
    {8'd4, 8'h00, 8'd5},
    {8'd3, 8'h3C, 8'd1},
    {8'd2, 8'hF0, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  wire  [7:0] data_o;

  int tests = 0;
  int fails = 0;

  int exp_t [0:511];
  int log_t [0:255];
  int gpoly [0:16];

  logic [7:0] expcw  [0:1][0:254];
  int         expkind[0:1];
  string      exptag [0:1];
  int         drv_blk = 0;

  logic [7:0] obs [0:254];
  int  cap_idx = 255;
  int  cur_buf = 0;
  int  mon_blk = 0;
  bit  st_prev = 1'b0;
  int  since = 1000;
  int  viol = 0;

  always #10 clk = ~clk;

  rs_fec_encoder u_rs_fec_encoder (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .data_i  (data_i),
    .data_o  (data_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[log_t[a] + log_t[b]];
  endfunction

  task automatic build_field();
    int x;
    x = 1;
    for (int k = 0; k < 255; k++) begin
      exp_t[k] = x;
      log_t[x] = k;
      x = x << 1;
      if (x & 256) x = x ^ 'h11D;
    end
    for (int k = 255; k < 512; k++) exp_t[k] = exp_t[k-255];
    log_t[0] = 0;
    for (int k = 0; k <= 16; k++) gpoly[k] = 0;
    gpoly[0] = 1;
    for (int i = 0; i < NPAR; i++) begin
      for (int k = 16; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ gmul(gpoly[k], exp_t[i]);
      gpoly[0] = gmul(gpoly[0], exp_t[i]);
    end
  endtask

  task automatic check_block(input int b);
    int bad_m, first_m, bad_p, first_p, s;
    bit syn_ok;
    bad_m = 0; first_m = 0; bad_p = 0; first_p = 0;
    for (int n = 0; n < NMSG; n++)
      if (obs[n] !== expcw[b][n]) begin if (bad_m == 0) first_m = n; bad_m++; end
    chk(bad_m == 0, "R4", "message bytes", obs[first_m], expcw[b][first_m]);
    for (int n = NMSG; n < NTOT; n++)
      if (obs[n] !== expcw[b][n]) begin if (bad_p == 0) first_p = n; bad_p++; end
    chk(bad_p == 0, "R5 R7", "parity bytes", obs[first_p], expcw[b][first_p]);
    chk(obs[NMSG-1] === expcw[b][NMSG-1] && obs[NMSG] === expcw[b][NMSG], "R2",
        "message/parity boundary", obs[NMSG], expcw[b][NMSG]);
    syn_ok = 1'b1;
    for (int i = 0; i < NPAR; i++) begin
      s = 0;
      for (int n = 0; n < NTOT; n++) s = gmul(s, exp_t[i]) ^ obs[n];
      if (s != 0) syn_ok = 1'b0;
    end
    chk(syn_ok, "R1", "codeword syndromes zero", syn_ok, 1);
    if (expkind[b] == 0)
      for (int j = 0; j < NPAR; j++)
        chk(obs[NMSG+j] == 0, "R5", "zero message parity", obs[NMSG+j], 0);
    if (expkind[b] == 1)
      for (int j = 0; j < NPAR; j++)
        chk(obs[NMSG+j] == gpoly[15-j], "R5", "impulse parity = generator", obs[NMSG+j], gpoly[15-j]);
    if (exptag[b] != "")
      chk(bad_p == 0 && syn_ok, exptag[b], "codeword after boundary event", obs[first_p], expcw[b][first_p]);
  endtask

  // output monitor, away from the active edge
  always @(posedge clk) begin
    #1;
    if (rst) begin
      cap_idx = 255;
      st_prev = 1'b0;
      since   = 1000;
    end else begin
      if (st_prev) begin
        cur_buf = mon_blk % 2;
        mon_blk++;
        cap_idx = 0;
      end
      if (cap_idx < NTOT) begin
        obs[cap_idx] = data_o;
        cap_idx++;
        if (cap_idx == NTOT) check_block(cur_buf);
      end else begin
        chk(data_o == 8'h00, "R8", "idle output", data_o, 0);
      end
      since++;
      if (start_i) begin
        if (since < NTOT) begin
          viol++;
          $display("[TB] protocol violation: START only %0d cycles after the previous one", since);
        end
        since = 0;
      end
      st_prev = start_i;
    end
  end

  task automatic make_msg(input int pat, input int seed, output logic [7:0] m [0:238]);
    logic [7:0] s;
    s = 8'(seed) | 8'h01;
    for (int n = 0; n < NMSG; n++) begin
      case (pat)
        0: m[n] = 8'h00;
        1: m[n] = (n == NMSG-1) ? 8'h01 : 8'h00;
        2: m[n] = 8'(seed + n);
        3: begin s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]}; m[n] = s; end
        default: m[n] = 8'hFF;
      endcase
    end
  endtask

  task automatic send_block(input int pat, input int seed, input int gap, input bit lat, input string tag);
    logic [7:0] m [0:238];
    int d [0:254];
    int q, b;
    make_msg(pat, seed, m);
    for (int n = 0; n < NTOT; n++) d[n] = (n < NMSG) ? int'(m[n]) : 0;
    // long division by the monic generator
    for (int n = 0; n < NMSG; n++) begin
      q = d[n];
      if (q != 0)
        for (int k = 0; k <= NPAR; k++) d[n+k] = d[n+k] ^ gmul(q, gpoly[NPAR-k]);
    end
    b = drv_blk % 2;
    drv_blk++;
    for (int n = 0; n < NMSG; n++) expcw[b][n] = m[n];
    for (int n = NMSG; n < NTOT; n++) expcw[b][n] = 8'(d[n]);
    expkind[b] = pat;
    exptag[b]  = tag;
    for (int n = 0; n < NTOT; n++) begin
      @(negedge clk);
      if (lat && n == 1) chk(data_o == 8'h00, "R3", "output one edge after first byte", data_o, 0);
      if (lat && n == 2) chk(data_o == m[0], "R3", "output two edges after first byte", data_o, m[0]);
      start_i = (n == 0);
      data_i  = (n < NMSG) ? m[n] : (8'h5A ^ 8'(n));
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      start_i = 1'b0;
      data_i  = 8'hC3 ^ 8'(g);
    end
  endtask

  task automatic send_partial(input int nbytes);
    drv_blk++;
    for (int n = 0; n < nbytes; n++) begin
      @(negedge clk);
      start_i = (n == 0);
      data_i  = 8'(n * 7 + 3);
    end
  endtask

  initial begin
    #3000000;
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    build_field();
    repeat (3) @(negedge clk);
    chk(data_o == 8'h00, "R9", "output held in reset", data_o, 0);
    rst = 1'b0;
    @(negedge clk);

    send_block(3, 8'h11, 2, 1'b1, "");

    for (int v = 0; v < 7; v++) begin
      send_block(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0,
                 (v > 0 && VEC[v-1][7:0] == 8'd0) ? "R6" : "");
    end
    chk(viol == 0, "R6", "255-cycle spacing raises no violation", viol, 0);

    // reset in the middle of a message
    send_partial(60);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(data_o == 8'h00, "R9", "output cleared by mid-block reset", data_o, 0);
    rst = 1'b0;
    @(negedge clk);
    send_block(3, 8'h99, 2, 1'b0, "R9");

    // premature START
    send_partial(100);
    send_block(2, 8'h40, 3, 1'b0, "R10");
    repeat (4) @(negedge clk);
    chk(viol == 1, "R10", "early START flagged once", viol, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule